// File: doc/BRIEF.md
# Symmetric FIR Compensation Filter

A five-tap linear-phase FIR filter sits in front of a DAC audio path. It flattens the frequency response of the converter. The two outer taps share one coefficient, the two inner taps share a second coefficient, and the centre tap has its own. Three 16-bit signed coefficients therefore describe the whole response. Because of this symmetry, each pair of mirrored samples is summed before it is multiplied, so each output sample costs three multiplies.

The coefficients come either from a built-in table or from registers that are written one byte at a time.

- A control bit chooses between the two sources.
- When the built-in table is in use, a 2-bit oversampling-mode input picks one of two hardwired sets.
- Samples enter with a valid strobe and leave with a valid strobe two cycles later.
- The result is scaled back from the Q1.15 coefficient format and rounded.
- The result saturates at the signed sample limits instead of wrapping.

Top module: `symfir_comp`

## Requirements
- R1: Each output equals floor((C0·(x[n]+x[n-4]) + C1·(x[n-1]+x[n-3]) + C2·x[n-2] + 2^14) / 2^15), taken before saturation. Here x[n] is the newest accepted sample. Samples and coefficients are signed two's complement.
- R2: While bit 0 of the control register at address 0x0E is 0, the filter uses a built-in coefficient set and the programmed coefficient registers have no effect. With oversampling mode 0 the set is C0=68, C1=-580, C2=27551. With modes 1, 2 and 3 the set is C0=112, C1=-412, C2=28526.
- R3: While bit 0 of the control register at address 0x0E is 1, the filter uses the programmed coefficients. Addresses 0x10, 0x11 and 0x12 take bits [15:8] of C0, C1 and C2. Addresses 0x13, 0x14 and 0x15 take bits [7:0] of C0, C1 and C2.
- R4: Writing a high byte only stages it, and the live coefficient is unchanged. The coefficient takes on the staged high byte together with the new low byte only when its low-byte address is written.
- R5: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R6: The output valid signal equals the input valid signal delayed by exactly two clock cycles. The output sample holds its value while the output valid signal is low.
- R7: The delay line advances only on cycles with the input valid signal high, so idle cycles between samples do not change any result.
- R8: Reset clears the output valid signal, the output sample, the delay line, the programmed coefficients and the control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write byte |
| osr_mode | input | 2 | Oversampling mode, selects the built-in set |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DW | Signed, saturated output sample |

## Verification
Impulses separate the three coefficients, because each coefficient appears alone in the response and the mirrored taps appear twice. Ramps and mixed-sign sequences put a distinct value on every tap, which exposes a wrong fold pairing or a swapped coefficient. Full-scale runs of one sign push the sum past both limits and separate saturation from wraparound. The same sequences are also sent with idle gaps, after high-byte-only writes, and after reset. These show that the delay line, the coefficient staging and the default selection respond only to the events meant to change them.

// File: rtl/symfir_comp.sv
module symfir_comp #(
  parameter int DW = 16,
  parameter logic [7:0] CTRL_ADDR = 8'h0E,
  parameter logic [7:0] MSB_ADDR = 8'h10,
  parameter logic [7:0] LSB_ADDR = 8'h13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic [1:0]    osr_mode,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  localparam int CW   = 16;
  localparam int NC   = 3;
  localparam int FRAC = CW - 1;
  localparam int AW   = DW + CW + 3;
  localparam logic signed [AW-1:0] RND  = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));
  localparam logic [NC-1:0][CW-1:0] DEF_LO = {16'sd27551, -16'sd580, 16'sd68};
  localparam logic [NC-1:0][CW-1:0] DEF_HI = {16'sd28526, -16'sd412, 16'sd112};

  logic [NC-1:0][7:0]    stg;
  logic [NC-1:0][CW-1:0] cst, ksel, k;
  logic                  cust_en;
  logic [3:0][DW-1:0]    dly;
  logic signed [DW:0]    s0, s1;
  logic signed [DW-1:0]  s2;
  logic                  v1;
  logic signed [AW-1:0]  acc, q;
  logic [DW-1:0]         sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cust_en <= 1'b0;
    else if (reg_we && reg_addr == CTRL_ADDR) cust_en <= reg_wdata[0];
  end

  for (genvar i = 0; i < NC; i++) begin : g_coef
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[i] <= '0;
        cst[i] <= '0;
      end else if (reg_we) begin
        if (reg_addr == MSB_ADDR + 8'(i)) stg[i] <= reg_wdata;
        if (reg_addr == LSB_ADDR + 8'(i)) cst[i] <= {stg[i], reg_wdata};
      end
    end
  end

  assign ksel = cust_en ? cst : (osr_mode == 2'b00 ? DEF_LO : DEF_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly <= '0;
      s0  <= '0;
      s1  <= '0;
      s2  <= '0;
      k   <= '0;
    end else if (in_valid) begin
      dly <= {dly[2:0], in_sample};
      s0  <= (DW+1)'($signed(in_sample)) + (DW+1)'($signed(dly[3]));
      s1  <= (DW+1)'($signed(dly[0])) + (DW+1)'($signed(dly[2]));
      s2  <= $signed(dly[1]);
      k   <= ksel;
    end
  end

  assign acc = AW'(s0) * AW'($signed(k[0]))
             + AW'(s1) * AW'($signed(k[1]))
             + AW'(s2) * AW'($signed(k[2]));
  assign q   = (acc + RND) >>> FRAC;
  assign sat = (q > MAXV) ? MAXV[DW-1:0] : (q < MINV) ? MINV[DW-1:0] : q[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1         <= 1'b0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (v1) out_sample <= sat;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd2 |-> out_valid == $past(in_valid, 2));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dly));

  // R4
  lsb_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr >= LSB_ADDR && reg_addr < LSB_ADDR + 8'(NC)) |=> $stable(cst));

  // R3
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == CTRL_ADDR) |=> $stable(cust_en));
endmodule

// File: tb/symfir_comp_tb.sv
module symfir_comp_tb_top;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0, reg_we = 0, in_valid = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic [1:0] osr_mode = 0;
  logic [DW-1:0] in_sample = 0;
  logic out_valid;
  logic [DW-1:0] out_sample;

  symfir_comp #(.DW(DW)) dut_i (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int hist[5];
  int c0, c1, c2;
  int exp_q[$];
  string tag_q[$];
  string cur = "R1";
  logic h1 = 0, h2 = 0;
  bit mon_on = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model();
    longint acc, r;
    acc = longint'(c0) * (hist[0] + hist[4]) + longint'(c1) * (hist[1] + hist[3])
        + longint'(c2) * hist[2];
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  always @(negedge clk) if (mon_on) begin
    if (out_valid || h2) chk("R6 latency", int'(out_valid), int'(h2));
    if (out_valid) begin
      if (exp_q.size() == 0) chk("R6 unexpected", 1, 0);
      else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, int'($signed(out_sample)), e);
      end
    end
    h2 = h1;
    h1 = in_valid;
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic wcoef(int idx, int v);
    wr(8'h10 + 8'(idx), 8'(v >>> 8));
    wr(8'h13 + 8'(idx), 8'(v));
  endtask

  task automatic send(int x, int gap);
    @(posedge clk); #2;
    in_valid = 1; in_sample = DW'(x);
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    exp_q.push_back(model());
    tag_q.push_back(cur);
    @(posedge clk); #2;
    in_valid = 0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic drain();
    repeat (5) @(posedge clk);
    chk({cur, " drain"}, exp_q.size(), 0);
  endtask

  task automatic do_reset();
    mon_on = 0;
    @(posedge clk); #2;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 out_valid", int'(out_valid), 0);
    chk("R8 out_sample", int'(out_sample), 0);
    foreach (hist[i]) hist[i] = 0;
    exp_q.delete(); tag_q.delete();
    h1 = 0; h2 = 0;
    rst_n = 1;
    mon_on = 1;
  endtask

  task automatic t_default_mode0();
    cur = "R2 osr0 R1";
    osr_mode = 0; c0 = 68; c1 = -580; c2 = 27551;
    send(16384, 0);
    for (int i = 0; i < 5; i++) send(0, 0);
    for (int i = 0; i < 6; i++) send(i * 3000 - 7000, 0);
    drain();
  endtask

  task automatic t_default_other();
    for (int m = 1; m < 4; m++) begin
      cur = "R2 osr123 R1";
      osr_mode = 2'(m); c0 = 112; c1 = -412; c2 = 28526;
      send(-20000, 0);
      for (int i = 0; i < 5; i++) send((i % 2) ? 9000 : -5000, 0);
      drain();
    end
  endtask

  task automatic t_custom();
    osr_mode = 0;
    wcoef(0, 1000); wcoef(1, -2000); wcoef(2, 20000);
    cur = "R2 ignored";
    c0 = 68; c1 = -580; c2 = 27551;
    for (int i = 0; i < 5; i++) send(1234 * i - 3000, 0);
    drain();
    wr(8'h0E, 8'h01);
    cur = "R3 custom";
    c0 = 1000; c1 = -2000; c2 = 20000;
    send(30000, 0);
    for (int i = 0; i < 5; i++) send(-777 * i, 0);
    drain();
  endtask

  task automatic t_msb_only();
    wr(8'h12, 8'h10);
    cur = "R4 msb only";
    for (int i = 0; i < 5; i++) send(4000 + 100 * i, 0);
    drain();
    wr(8'h15, 8'h22);
    cur = "R4 lsb commit";
    c2 = 16'h1022;
    for (int i = 0; i < 5; i++) send(-3000 + 50 * i, 0);
    drain();
  endtask

  task automatic t_saturate();
    wcoef(0, 32767); wcoef(1, 32767); wcoef(2, 32767);
    c0 = 32767; c1 = 32767; c2 = 32767;
    cur = "R5 sat pos";
    for (int i = 0; i < 6; i++) send(32767, 0);
    cur = "R5 sat neg";
    for (int i = 0; i < 6; i++) send(-32768, 0);
    drain();
  endtask

  task automatic t_gaps();
    wcoef(0, -300); wcoef(1, 2500); wcoef(2, 12000);
    c0 = -300; c1 = 2500; c2 = 12000;
    cur = "R7 gaps";
    for (int i = 0; i < 8; i++) send(2500 * i - 9000, i % 4);
    drain();
  endtask

  task automatic t_reset_clears();
    do_reset();
    wr(8'h0E, 8'h01);
    cur = "R8 coef cleared";
    c0 = 0; c1 = 0; c2 = 0;
    for (int i = 0; i < 5; i++) send(15000 - i, 0);
    drain();
    do_reset();
    cur = "R8 defaults";
    osr_mode = 1; c0 = 112; c1 = -412; c2 = 28526;
    for (int i = 0; i < 5; i++) send(8000 * (i - 2), 0);
    drain();
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_default_mode0();
    t_default_other();
    t_custom();
    t_msb_only();
    t_saturate();
    t_gaps();
    t_reset_clears();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule